// File: doc/BRIEF.md
# Parallel LCD Bus Strobe Timing Generator

This block drives the pins of an 8080-style parallel display bus: a chip select, a write strobe, a read strobe, a command/data select line (A0) and a data bus with an output enable. A host hands over one bus request at a time through a valid/ready port. A request is a command write, a data (parameter or pixel) write, or a read. For a read, accepting the request starts the bus cycle. The word found on the input bus at the programmed sample tick is then offered on a valid/ready read-data port.

Every strobe edge sits at its own programmable tick inside the bus cycle. The tick positions come from two packed timing words plus a sample-tick field, loaded with a single configuration strobe. A granularity bit selects a tick of one or two system clocks. After each bus cycle the chip select stays inactive for a programmable recovery gap. A timing set that breaks the ordering rules raises a sticky error and parks the bus until a legal set is loaded.

Back-pressure rules: `req_ready` is high only when no cycle or recovery gap is running, the timing set is legal, no captured read word is waiting, and `cfg_wr` is low. `rd_valid` stays high, with `rd_data` unchanged, until the clock edge at which `rd_ready` is high.

Top module: `lcd_strobe_gen`

## Requirements
- R1: After reset the block is idle. `busy`, `rd_valid` and `cfg_err` are low and `req_ready` is high. All three strobes are at their inactive level. A built-in legal timing set is in force: CS ticks 0..1, WE tick 0, RE tick 0, both cycle lengths 2, gap 0, sample tick 1, tick of one clock.
- R2: During a bus cycle, chip select is active exactly on the ticks t with cs_on <= t < cs_off, where tick 0 is the first tick after acceptance. It is inactive at every other time, including during the recovery gap.
- R3: For a write, WE is active on the ticks t with we_on <= t < we_off. `lcd_doe` is high and `lcd_dout` carries the accepted word for the whole write cycle. RE stays inactive.
- R4: For a read, RE is active on the ticks t with re_on <= t < re_off. `lcd_doe` is low and WE stays inactive.
- R5: `req_kind` bit 1 selects read (1) or write (0), and bit 0 selects data (1) or command (0). `lcd_a0` equals kind bit 0 XOR `a0_pol` from the clock after acceptance, and it keeps that value until the next accepted request.
- R6: On a read, `lcd_din` is captured at the last system clock of tick `sample`, and `rd_valid` rises at that same edge. `rd_valid` and `rd_data` then hold until a clock edge at which `rd_ready` is high.
- R7: `busy` is high from the clock after acceptance for (wr_len or rd_len) ticks plus cs_gap ticks. One tick lasts one system clock when `cfg_gran` is 0 and two system clocks when it is 1.
- R8: The on/off word holds CS-on [3:0], CS-off [9:4], WE-on [13:10], WE-off [19:14], RE-on [23:20] and RE-off [29:24]. The cycle word holds the write length [5:0], the read length [11:6] and the gap [17:12]. A loaded set is legal only if all of these hold: we_off > we_on, re_off > re_on, wr_len >= we_off, rd_len >= re_off, cs_off > cs_on, cs_off >= max(we_off, re_off), and re_on < sample < rd_len. An illegal set sets `cfg_err` and keeps the bus idle with `req_ready` low. The error stays set until a legal set is loaded.
- R9: `req_ready` follows the back-pressure rule stated above. A `cfg_wr` pulse that arrives while `busy` is high is ignored.
- R10: Each of CS, WE and RE has its own polarity input. With polarity 0 the pin is low when active, and with polarity 1 it is high when active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Load strobe for the timing fields |
| cfg_onoff | input | 30 | Strobe on/off tick word |
| cfg_cycle | input | 18 | Cycle lengths and recovery gap word |
| cfg_acc | input | 6 | Read sample tick |
| cfg_gran | input | 1 | Tick size: 0 = one clock, 1 = two clocks |
| cs_pol | input | 1 | Chip select active level |
| we_pol | input | 1 | Write strobe active level |
| re_pol | input | 1 | Read strobe active level |
| a0_pol | input | 1 | Inverts the A0 level |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_kind | input | 2 | Bit 1: read; bit 0: data (not command) |
| req_data | input | 16 | Word to write |
| rd_valid | output | 1 | Captured read word available |
| rd_ready | input | 1 | Host takes the read word |
| rd_data | output | 16 | Captured read word |
| busy | output | 1 | Bus cycle or recovery gap running |
| cfg_err | output | 1 | Sticky illegal-timing flag |
| lcd_cs | output | 1 | Chip select pin |
| lcd_we | output | 1 | Write strobe pin |
| lcd_re | output | 1 | Read strobe pin |
| lcd_a0 | output | 1 | Command/data select pin |
| lcd_dout | output | 16 | Data bus, outbound |
| lcd_doe | output | 1 | Data bus output enable |
| lcd_din | input | 16 | Data bus, inbound |

## Verification
The hardest case to reach is a captured read word left unfetched. In that state the sticky hold on `rd_valid` has to stall every further request, and the capture has to land on the second clock of a two-clock sample tick. The stimulus holds `rd_ready` low through a read under the two-clock granularity. Meanwhile `lcd_din` changes on every clock, so a capture one clock early or late shows up as a different word. A second hard case is a configuration write that arrives during a bus cycle. The bench loads an illegal set while a write is still running, then checks that the error flag stays clear and that later requests still complete.

// File: rtl/lcdb_pkg.sv
package lcdb_pkg;
  parameter int ON_W  = 4;
  parameter int OFF_W = 6;
  localparam int SEG_W   = ON_W + OFF_W;
  localparam int ONOFF_W = 3 * SEG_W;
  localparam int CYC_W   = 3 * OFF_W;

  typedef logic [OFF_W-1:0] tick_t;

  typedef struct packed {
    tick_t cs_on;
    tick_t cs_off;
    tick_t we_on;
    tick_t we_off;
    tick_t re_on;
    tick_t re_off;
    tick_t wr_len;
    tick_t rd_len;
    tick_t cs_gap;
    tick_t sample;
    logic  half_rate;
  } bus_timing_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_GAP  = 2'd2
  } seq_state_t;

  localparam bus_timing_t BOOT_TIMING = '{
    cs_on: tick_t'(0), cs_off: tick_t'(2),
    we_on: tick_t'(0), we_off: tick_t'(1),
    re_on: tick_t'(0), re_off: tick_t'(1),
    wr_len: tick_t'(2), rd_len: tick_t'(2),
    cs_gap: tick_t'(0), sample: tick_t'(1),
    half_rate: 1'b0
  };

  function automatic tick_t widen_on(input logic [ON_W-1:0] v);
    return tick_t'(v);
  endfunction

  function automatic bus_timing_t unpack_timing(
      input logic [ONOFF_W-1:0] onoff,
      input logic [CYC_W-1:0]   cyc,
      input tick_t              acc,
      input logic               gran);
    bus_timing_t r;
    r.cs_on     = widen_on(onoff[0 +: ON_W]);
    r.cs_off    = onoff[ON_W +: OFF_W];
    r.we_on     = widen_on(onoff[SEG_W +: ON_W]);
    r.we_off    = onoff[SEG_W + ON_W +: OFF_W];
    r.re_on     = widen_on(onoff[2*SEG_W +: ON_W]);
    r.re_off    = onoff[2*SEG_W + ON_W +: OFF_W];
    r.wr_len    = cyc[0 +: OFF_W];
    r.rd_len    = cyc[OFF_W +: OFF_W];
    r.cs_gap    = cyc[2*OFF_W +: OFF_W];
    r.sample    = acc;
    r.half_rate = gran;
    return r;
  endfunction

  function automatic logic timing_ok(input bus_timing_t c);
    tick_t last_strobe;
    last_strobe = (c.we_off > c.re_off) ? c.we_off : c.re_off;
    return (c.we_off > c.we_on) && (c.re_off > c.re_on) &&
           (c.wr_len >= c.we_off) && (c.rd_len >= c.re_off) &&
           (c.cs_off > c.cs_on) && (c.cs_off >= last_strobe) &&
           (c.sample > c.re_on) && (c.sample < c.rd_len);
  endfunction

  function automatic logic in_window(input tick_t t, input tick_t lo,
                                     input tick_t hi);
    return (t >= lo) && (t < hi);
  endfunction
endpackage

// File: rtl/lcdb_cfg_store.sv
module lcdb_cfg_store
  import lcdb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [ONOFF_W-1:0]  onoff,
  input  logic [CYC_W-1:0]    cyc,
  input  tick_t               acc,
  input  logic                gran,
  output bus_timing_t         tim,
  output logic                err
);
  bus_timing_t cand;

  always_comb cand = unpack_timing(onoff, cyc, acc, gran);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tim <= BOOT_TIMING;
      err <= 1'b0;
    end else if (load) begin
      tim <= cand;
      err <= !timing_ok(cand);
    end
  end
endmodule

// File: rtl/lcdb_tick_pace.sv
module lcdb_tick_pace (
  input  logic clk,
  input  logic rst_n,
  input  logic running,
  input  logic half_rate,
  output logic tick_last
);
  logic phase;

  always_ff @(posedge clk) begin
    if (!rst_n || !running) phase <= 1'b0;
    else if (half_rate)     phase <= ~phase;
    else                    phase <= 1'b0;
  end

  assign tick_last = !half_rate || phase;
endmodule

// File: rtl/lcdb_seq.sv
module lcdb_seq
  import lcdb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tick_t             wr_len,
  input  tick_t             rd_len,
  input  tick_t             cs_gap,
  input  tick_t             sample,
  input  logic              err,
  input  logic              tick_last,
  input  logic              cfg_wr,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [DATA_W-1:0] req_data,
  output logic              req_ready,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] bus_din,
  output logic              busy,
  output logic              run,
  output tick_t             t,
  output logic              is_read,
  output logic              a0_q,
  output logic [DATA_W-1:0] data_q
);
  seq_state_t state;
  tick_t      len;
  logic       accept;
  logic       capture;
  logic       len_done;
  logic       gap_done;

  assign busy      = (state != ST_IDLE);
  assign run       = (state == ST_RUN);
  assign req_ready = !busy && !err && !rd_valid && !cfg_wr;
  assign accept    = req_valid && req_ready;
  assign len       = is_read ? rd_len : wr_len;
  assign len_done  = (t == len - OFF_W'(1));
  assign gap_done  = (t == cs_gap - OFF_W'(1));
  assign capture   = run && is_read && tick_last && (t == sample);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      t     <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          t <= '0;
          if (accept) state <= ST_RUN;
        end
        ST_RUN: if (tick_last) begin
          if (len_done) begin
            t     <= '0;
            state <= (cs_gap == '0) ? ST_IDLE : ST_GAP;
          end else begin
            t <= t + OFF_W'(1);
          end
        end
        ST_GAP: if (tick_last) begin
          if (gap_done) begin
            t     <= '0;
            state <= ST_IDLE;
          end else begin
            t <= t + OFF_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      is_read <= 1'b0;
      a0_q    <= 1'b0;
      data_q  <= '0;
    end else if (accept) begin
      is_read <= req_kind[1];
      a0_q    <= req_kind[0];
      data_q  <= req_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else if (capture) begin
      rd_valid <= 1'b1;
      rd_data  <= bus_din;
    end else if (rd_ready) begin
      rd_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/lcdb_pin_drive.sv
module lcdb_pin_drive
  import lcdb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              run,
  input  tick_t             t,
  input  logic              is_read,
  input  logic              a0_q,
  input  logic [DATA_W-1:0] data_q,
  input  tick_t             cs_on,
  input  tick_t             cs_off,
  input  tick_t             we_on,
  input  tick_t             we_off,
  input  tick_t             re_on,
  input  tick_t             re_off,
  input  logic              cs_pol,
  input  logic              we_pol,
  input  logic              re_pol,
  input  logic              a0_pol,
  output logic              lcd_cs,
  output logic              lcd_we,
  output logic              lcd_re,
  output logic              lcd_a0,
  output logic [DATA_W-1:0] lcd_dout,
  output logic              lcd_doe
);
  localparam int N_STROBE = 3;

  logic [N_STROBE-1:0] act;
  logic [N_STROBE-1:0] pol;
  logic [N_STROBE-1:0] pin;

  assign act[0] = run && in_window(t, cs_on, cs_off);
  assign act[1] = run && !is_read && in_window(t, we_on, we_off);
  assign act[2] = run && is_read && in_window(t, re_on, re_off);
  assign pol    = {re_pol, we_pol, cs_pol};

  for (genvar g = 0; g < N_STROBE; g++) begin : g_strobe
    assign pin[g] = pol[g] ? act[g] : ~act[g];
  end

  assign lcd_cs   = pin[0];
  assign lcd_we   = pin[1];
  assign lcd_re   = pin[2];
  assign lcd_a0   = a0_q ^ a0_pol;
  assign lcd_doe  = run && !is_read;
  assign lcd_dout = data_q;
endmodule

// File: rtl/lcd_strobe_gen.sv
module lcd_strobe_gen
  import lcdb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [ONOFF_W-1:0] cfg_onoff,
  input  logic [CYC_W-1:0]   cfg_cycle,
  input  logic [OFF_W-1:0]   cfg_acc,
  input  logic               cfg_gran,
  input  logic               cs_pol,
  input  logic               we_pol,
  input  logic               re_pol,
  input  logic               a0_pol,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_kind,
  input  logic [DATA_W-1:0]  req_data,
  output logic               rd_valid,
  input  logic               rd_ready,
  output logic [DATA_W-1:0]  rd_data,
  output logic               busy,
  output logic               cfg_err,
  output logic               lcd_cs,
  output logic               lcd_we,
  output logic               lcd_re,
  output logic               lcd_a0,
  output logic [DATA_W-1:0]  lcd_dout,
  output logic               lcd_doe,
  input  logic [DATA_W-1:0]  lcd_din
);
  bus_timing_t       tim;
  logic              tick_last;
  logic              run;
  tick_t             t;
  logic              is_read;
  logic              a0_q;
  logic [DATA_W-1:0] data_q;

  lcdb_cfg_store u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cfg_wr && !busy),
    .onoff (cfg_onoff),
    .cyc   (cfg_cycle),
    .acc   (cfg_acc),
    .gran  (cfg_gran),
    .tim   (tim),
    .err   (cfg_err)
  );

  lcdb_tick_pace u_pace (
    .clk       (clk),
    .rst_n     (rst_n),
    .running   (busy),
    .half_rate (tim.half_rate),
    .tick_last (tick_last)
  );

  lcdb_seq #(.DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_len    (tim.wr_len),
    .rd_len    (tim.rd_len),
    .cs_gap    (tim.cs_gap),
    .sample    (tim.sample),
    .err       (cfg_err),
    .tick_last (tick_last),
    .cfg_wr    (cfg_wr),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .req_data  (req_data),
    .req_ready (req_ready),
    .rd_ready  (rd_ready),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .bus_din   (lcd_din),
    .busy      (busy),
    .run       (run),
    .t         (t),
    .is_read   (is_read),
    .a0_q      (a0_q),
    .data_q    (data_q)
  );

  lcdb_pin_drive #(.DATA_W(DATA_W)) u_pins (
    .run      (run),
    .t        (t),
    .is_read  (is_read),
    .a0_q     (a0_q),
    .data_q   (data_q),
    .cs_on    (tim.cs_on),
    .cs_off   (tim.cs_off),
    .we_on    (tim.we_on),
    .we_off   (tim.we_off),
    .re_on    (tim.re_on),
    .re_off   (tim.re_off),
    .cs_pol   (cs_pol),
    .we_pol   (we_pol),
    .re_pol   (re_pol),
    .a0_pol   (a0_pol),
    .lcd_cs   (lcd_cs),
    .lcd_we   (lcd_we),
    .lcd_re   (lcd_re),
    .lcd_a0   (lcd_a0),
    .lcd_dout (lcd_dout),
    .lcd_doe  (lcd_doe)
  );
endmodule

// File: rtl/lcd_strobe_gen_chk.sv
module lcd_strobe_gen_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              busy,
  input logic              cfg_err,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic              lcd_cs,
  input logic              lcd_we,
  input logic              lcd_re,
  input logic              lcd_doe,
  input logic              cs_pol,
  input logic              we_pol,
  input logic              re_pol
);
  logic cs_act, we_act, re_act;
  assign cs_act = (lcd_cs == cs_pol);
  assign we_act = (lcd_we == we_pol);
  assign re_act = (lcd_re == re_pol);

  a_r7_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cs_act && !we_act && !re_act));

  a_r7_accept_starts_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  a_r3_we_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    we_act |-> lcd_doe);

  a_r4_re_never_drives: assert property (@(posedge clk) disable iff (!rst_n)
    re_act |-> !lcd_doe);

  a_r6_read_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  a_r8_error_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !req_ready);

  a_r9_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!busy && !rd_valid));
endmodule

bind lcd_strobe_gen lcd_strobe_gen_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .busy      (busy),
  .cfg_err   (cfg_err),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_data   (rd_data),
  .lcd_cs    (lcd_cs),
  .lcd_we    (lcd_we),
  .lcd_re    (lcd_re),
  .lcd_doe   (lcd_doe),
  .cs_pol    (cs_pol),
  .we_pol    (we_pol),
  .re_pol    (re_pol)
);

// File: tb/lcd_strobe_gen_tb_top.sv
`timescale 1ns/1ps
module lcd_strobe_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [29:0] cfg_onoff = '0;
  logic [17:0] cfg_cycle = '0;
  logic [5:0]  cfg_acc = '0;
  logic        cfg_gran = 1'b0;
  logic        cs_pol = 1'b0, we_pol = 1'b0, re_pol = 1'b0, a0_pol = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = '0;
  logic [15:0] req_data = '0;
  logic        rd_valid;
  logic        rd_ready = 1'b1;
  logic [15:0] rd_data;
  logic        busy, cfg_err;
  logic        lcd_cs, lcd_we, lcd_re, lcd_a0, lcd_doe;
  logic [15:0] lcd_dout;
  logic [15:0] lcd_din = 16'h0100;

  int total = 0;
  int bad = 0;
  int we_clocks = 0;

  always #4 clk = ~clk;

  lcd_strobe_gen dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_onoff(cfg_onoff),
    .cfg_cycle(cfg_cycle), .cfg_acc(cfg_acc), .cfg_gran(cfg_gran),
    .cs_pol(cs_pol), .we_pol(we_pol), .re_pol(re_pol), .a0_pol(a0_pol),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_data(req_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .busy(busy), .cfg_err(cfg_err), .lcd_cs(lcd_cs),
    .lcd_we(lcd_we), .lcd_re(lcd_re), .lcd_a0(lcd_a0), .lcd_dout(lcd_dout),
    .lcd_doe(lcd_doe), .lcd_din(lcd_din)
  );

  // inbound bus data changes every clock so the capture instant is visible
  always @(posedge clk) lcd_din <= lcd_din + 16'h0103;

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_st, m_t, m_ph, m_kind, m_data, m_a0, m_rdv, m_rdd, m_err;
  int m_cson, m_csoff, m_weon, m_weoff, m_reon, m_reoff;
  int m_wrl, m_rdl, m_gap, m_acc, m_gran;

  function automatic bit legal_set(int cson, int csoff, int weon, int weoff,
      int reon, int reoff, int wrl, int rdl, int acc);
    int mx;
    mx = (weoff > reoff) ? weoff : reoff;
    return (weoff > weon) && (reoff > reon) && (wrl >= weoff) &&
           (rdl >= reoff) && (csoff > cson) && (csoff >= mx) &&
           (acc > reon) && (acc < rdl);
  endfunction

  always @(posedge clk) begin
    int st0, tl, acc_now, len;
    if (!rst_n) begin
      m_st = 0; m_t = 0; m_ph = 0; m_kind = 0; m_data = 0; m_a0 = 0;
      m_rdv = 0; m_rdd = 0; m_err = 0;
      m_cson = 0; m_csoff = 2; m_weon = 0; m_weoff = 1; m_reon = 0;
      m_reoff = 1; m_wrl = 2; m_rdl = 2; m_gap = 0; m_acc = 1; m_gran = 0;
    end else begin
      st0 = m_st;
      acc_now = req_valid && st0 == 0 && !m_err && !m_rdv && !cfg_wr;
      tl = (m_gran == 0) || (m_ph == 1);
      if (m_rdv && rd_ready) m_rdv = 0;
      if (st0 == 1 && m_kind[1] && tl && m_t == m_acc) begin
        m_rdv = 1; m_rdd = lcd_din;
      end
      if (st0 != 0 && m_gran == 1) m_ph = 1 - m_ph; else m_ph = 0;
      if (st0 == 1 && tl) begin
        len = m_kind[1] ? m_rdl : m_wrl;
        if (m_t == len - 1) begin m_t = 0; m_st = (m_gap == 0) ? 0 : 2; end
        else m_t = m_t + 1;
      end else if (st0 == 2 && tl) begin
        if (m_t == m_gap - 1) begin m_t = 0; m_st = 0; end
        else m_t = m_t + 1;
      end
      if (cfg_wr && st0 == 0) begin
        m_cson = cfg_onoff[3:0];   m_csoff = cfg_onoff[9:4];
        m_weon = cfg_onoff[13:10]; m_weoff = cfg_onoff[19:14];
        m_reon = cfg_onoff[23:20]; m_reoff = cfg_onoff[29:24];
        m_wrl = cfg_cycle[5:0]; m_rdl = cfg_cycle[11:6];
        m_gap = cfg_cycle[17:12]; m_acc = cfg_acc; m_gran = cfg_gran;
        m_err = !legal_set(m_cson, m_csoff, m_weon, m_weoff, m_reon,
                           m_reoff, m_wrl, m_rdl, m_acc);
      end
      if (acc_now) begin
        m_st = 1; m_t = 0; m_ph = 0; m_kind = req_kind;
        m_data = req_data; m_a0 = req_kind[0];
      end
    end
  end

  function automatic bit pin_level(bit act, bit pol);
    return pol ? act : !act;
  endfunction

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    bit run, wr;
    #2;
    if (rst_n) begin
      run = (m_st == 1);
      wr  = run && !m_kind[1];
      check("R2", "lcd_cs", lcd_cs,
            pin_level(run && m_t >= m_cson && m_t < m_csoff, cs_pol));
      check("R3", "lcd_we", lcd_we,
            pin_level(wr && m_t >= m_weon && m_t < m_weoff, we_pol));
      check("R4", "lcd_re", lcd_re,
            pin_level(run && m_kind[1] && m_t >= m_reon && m_t < m_reoff, re_pol));
      check("R5", "lcd_a0", lcd_a0, m_a0 ^ a0_pol);
      check("R3", "lcd_doe", lcd_doe, wr);
      if (wr) check("R3", "lcd_dout", lcd_dout, m_data);
      check("R7", "busy", busy, m_st != 0);
      check("R9", "req_ready", req_ready,
            m_st == 0 && !m_err && !m_rdv && !cfg_wr);
      check("R6", "rd_valid", rd_valid, m_rdv);
      if (m_rdv) check("R6", "rd_data", rd_data, m_rdd);
      check("R8", "cfg_err", cfg_err, m_err);
      if (lcd_we == we_pol) we_clocks++;
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input logic [1:0] kind, input logic [15:0] data);
    @(negedge clk);
    req_kind = kind; req_data = data; req_valid = 1'b1;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk); #1;
    while (busy) begin @(negedge clk); #1; end
  endtask

  task automatic load_cfg(input int cson, csoff, weon, weoff, reon, reoff,
                          input int wrl, rdl, gap, acc, gran);
    @(negedge clk);
    cfg_onoff = (30'(reoff) << 24) | (30'(reon) << 20) | (30'(weoff) << 14) |
                (30'(weon) << 10) | (30'(csoff) << 4) | 30'(cson);
    cfg_cycle = (18'(gap) << 12) | (18'(rdl) << 6) | 18'(wrl);
    cfg_acc = 6'(acc); cfg_gran = gran[0]; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    check("R1", "busy", busy, 0);
    check("R1", "req_ready", req_ready, 1);
    check("R1", "cfg_err", cfg_err, 0);
    check("R1", "rd_valid", rd_valid, 0);
    check("R1", "cs idle", {lcd_cs, lcd_we, lcd_re}, 3'b111);

    // boot timing set
    send(2'b00, 16'h1234);
    send(2'b01, 16'hBEEF);
    send(2'b10, 16'h0000);
    wait_idle();

    // set A, one-clock tick
    load_cfg(1, 9, 2, 5, 1, 7, 6, 9, 2, 4, 0);
    #1 check("R8", "legal A", cfg_err, 0);
    send(2'b00, 16'hA5C3);
    send(2'b11, 16'h0000);
    a0_pol = 1'b1;
    send(2'b01, 16'h5A3C);
    wait_idle();
    we_clocks = 0;
    send(2'b01, 16'h0F0F);
    wait_idle();
    check("R3", "we clocks one-clock tick", we_clocks, 3);

    // R10 polarity inversion
    cs_pol = 1'b1; we_pol = 1'b1; re_pol = 1'b1;
    @(negedge clk); #1;
    check("R10", "idle strobes high-active", {lcd_cs, lcd_we, lcd_re}, 3'b000);

    // set B, two-clock tick
    load_cfg(0, 8, 1, 4, 2, 6, 5, 7, 1, 5, 1);
    send(2'b01, 16'h1111);
    send(2'b10, 16'h0000);
    wait_idle();
    we_clocks = 0;
    send(2'b00, 16'h2222);
    wait_idle();
    check("R7", "we clocks two-clock tick", we_clocks, 6);

    // R6 read word held under back-pressure
    rd_ready = 1'b0;
    send(2'b10, 16'h0000);
    wait_idle();
    repeat (3) @(negedge clk);
    #1;
    check("R6", "rd_valid held", rd_valid, 1);
    check("R9", "ready low while word waits", req_ready, 0);
    rd_ready = 1'b1;
    @(negedge clk); #1;
    check("R6", "rd_valid cleared", rd_valid, 0);

    // R8 illegal sets
    cs_pol = 1'b0; we_pol = 1'b0; re_pol = 1'b0;
    load_cfg(1, 9, 3, 3, 1, 7, 6, 9, 0, 4, 0);
    #1 check("R8", "we_off==we_on", cfg_err, 1);
    req_kind = 2'b01; req_valid = 1'b1;
    repeat (4) @(negedge clk);
    #1 check("R8", "bus parked", {busy, lcd_cs}, 2'b01);
    req_valid = 1'b0;
    load_cfg(1, 9, 2, 5, 4, 7, 6, 9, 0, 4, 0);
    #1 check("R8", "sample not after re_on", cfg_err, 1);
    load_cfg(1, 9, 2, 5, 1, 7, 6, 9, 2, 4, 1);
    #1 check("R8", "legal set clears", cfg_err, 0);

    // R9 configuration write while busy is ignored
    send(2'b01, 16'h7777);
    load_cfg(5, 2, 3, 3, 1, 1, 0, 0, 0, 0, 0);
    wait_idle();
    check("R9", "busy cfg_wr ignored", cfg_err, 0);
    send(2'b10, 16'h0000);
    wait_idle();
    repeat (2) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule